// File: doc/BRIEF.md
# LED Blink Generator with Auto-Stop

This block drives one LED output with a programmable blink pattern. A free-running clock is divided by a selectable power of two to produce a tick. A 12-bit phase counter advances on each tick and wraps after a programmed period length. The output is high during the first part of each period, up to a programmed on-time.

An optional auto-stop mode counts completed periods from a programmed start value. When that count runs out, blinking ends with the output low. A sticky interrupt flag is then raised, unless the interrupt is masked. Software programs the block through a write-only address/data port. Any write to the control register restarts or halts the pattern and clears the flag.

Top module: `led_blinker`

## Requirements
- R1: After reset `led_o` and `irq_o` are both low.
- R2: Control bits [3:0] hold a divide select n. The phase counter advances once every 2^(13-n) clock cycles, so n = 13 advances it on every clock.
- R3: A divide select above 13 behaves exactly as 13.
- R4: The phase counter runs from 0 up to the period value P and then wraps to 0, so one period lasts P+1 ticks.
- R5: While running, `led_o` is high exactly when the phase counter is below the on-time value D. D = 0 keeps it low, and D > P keeps it high.
- R6: Control bit 4 is the run enable. A control write with bit 4 set restarts the pattern at phase 0 and prescaler 0. With bit 4 clear, it halts the pattern at once with `led_o` low.
- R7: With control bit 5 set, the pattern halts with `led_o` low at the end of the N-th completed period. N is the stop count latched at the last control write, and N = 0 behaves as N = 1.
- R8: An auto-stop completion sets the sticky `irq_o` unless control bit 6 (mask) is set. A control write clears it. If a completion and a control write land on the same clock edge, the flag ends up set.
- R9: Write offsets are 0x0 control (bits [6:0]), 0x4 period (12 bits), 0x8 on-time (12 bits) and 0xC stop count (16 bits). The period and on-time take effect at once. The stop count is copied into the running down-counter only on a control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register byte offset |
| wr_data_i | input | 16 | Register write data |
| led_o | output | 1 | Blink output |
| irq_o | output | 1 | Sticky auto-stop interrupt |

## Verification
Two events can land on the same clock edge: the final period end of an auto-stop run, and a software control write that clears the flag and restarts the pattern. The bench provokes this with a one-period run at a divide select of 13. It places the next control write exactly on the second clock edge, where the run completes. The result is judged at the ports. The flag must read high, because setting wins over clearing. The output must read high, because the restart wins over the halt and phase 0 is below the on-time. A further control write must then bring the flag low.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CNT_W  = 12;
  localparam int unsigned STOP_W = 16;
  localparam int unsigned SEL_W  = 4;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_PER  = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_ON   = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_STOP = 4'hC;

  typedef struct packed {
    logic             irq_mask;
    logic             auto_stop;
    logic             run_en;
    logic [SEL_W-1:0] div_sel;
  } ctrl_t;
endpackage

// File: rtl/led_blink_regs.sv
module led_blink_regs
  import led_blink_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o,
  output logic              ctrl_wr_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  on_time_o,
  output logic [STOP_W-1:0] stop_cnt_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  assign ctrl_wr_o = wr_en_i && (wr_addr_i == OFF_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= '0;
      period_o   <= '0;
      on_time_o  <= '0;
      stop_cnt_o <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        OFF_CTRL: ctrl_o     <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        OFF_PER:  period_o   <= wr_data_i[CNT_W-1:0];
        OFF_ON:   on_time_o  <= wr_data_i[CNT_W-1:0];
        OFF_STOP: stop_cnt_o <= wr_data_i[STOP_W-1:0];
        default: ;
      endcase
    end
  end

  assert_ctrl_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_o |=> ctrl_o == ctrl_t'($past(wr_data_i[CTRL_W-1:0])));
endmodule

// File: rtl/led_blink_prescale.sv
module led_blink_prescale
  import led_blink_pkg::*;
#(
  parameter int unsigned MAX_SHIFT = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned PW = MAX_SHIFT + 1;
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(MAX_SHIFT);

  logic [SEL_W-1:0] sel_eff, shamt;
  logic [PW-1:0]    mask, cnt_q;

  always_comb begin
    sel_eff = (sel_i > SEL_MAX) ? SEL_MAX : sel_i;  // clamp out-of-range select
    shamt   = SEL_MAX - sel_eff;
    mask    = (PW'(1) << shamt) - PW'(1);
  end

  assign tick_o = run_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (restart_i || !run_i)   cnt_q <= '0;
    else                            cnt_q <= cnt_q + PW'(1);
  end

  // below the top rate, ticks are never back to back
  assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && run_i && !restart_i && sel_i < SEL_MAX) |=>
      (!$stable(sel_i) || restart_i || !tick_o));

  assert_prescale_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/led_blink_core.sv
module led_blink_core
  import led_blink_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ctrl_wr_i,
  input  logic              new_en_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  on_time_i,
  input  logic [STOP_W-1:0] stop_load_i,
  input  logic              auto_i,
  input  logic              mask_i,
  output logic              run_o,
  output logic              led_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  phase_q;
  logic [STOP_W-1:0] left_q;
  logic              run_q, irq_q;
  logic              wrap, done;

  assign wrap  = run_q && tick_i && (phase_q >= period_i);
  assign done  = wrap && auto_i && (left_q <= STOP_W'(1));
  assign run_o = run_q;
  assign led_o = run_q && (phase_q < on_time_i);
  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      left_q  <= '0;
      run_q   <= 1'b0;
    end else if (ctrl_wr_i) begin
      phase_q <= '0;
      left_q  <= stop_load_i;
      run_q   <= new_en_i;
    end else if (run_q && tick_i) begin
      if (wrap) begin
        phase_q <= '0;
        if (auto_i && left_q != '0) left_q <= left_q - STOP_W'(1);
        if (done) run_q <= 1'b0;
      end else begin
        phase_q <= phase_q + CNT_W'(1);
      end
    end
  end

  // set beats clear when both land on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               irq_q <= 1'b0;
    else if (done && !mask_i)  irq_q <= 1'b1;
    else if (ctrl_wr_i)        irq_q <= 1'b0;
  end

  assert_phase_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i && !ctrl_wr_i) |=> phase_q <= $past(period_i));

  assert_stop_resets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(run_q) && !$past(ctrl_wr_i)) |-> (phase_q == '0 && $past(auto_i)));

  assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !ctrl_wr_i) |=> irq_q);

  assert_irq_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> !$past(mask_i));

  assert_halted_dark_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && !new_en_i) |=> (!led_o && phase_q == '0));
endmodule

// File: rtl/led_blinker.sv
module led_blinker
  import led_blink_pkg::*;
#(
  parameter int unsigned MAX_SHIFT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              led_o,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic              ctrl_wr, tick, run;
  logic [CNT_W-1:0]  period, on_time;
  logic [STOP_W-1:0] stop_cnt;

  led_blink_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .ctrl_o     (ctrl),
    .ctrl_wr_o  (ctrl_wr),
    .period_o   (period),
    .on_time_o  (on_time),
    .stop_cnt_o (stop_cnt)
  );

  led_blink_prescale #(.MAX_SHIFT(MAX_SHIFT)) u_prescale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (ctrl_wr),
    .sel_i     (ctrl.div_sel),
    .tick_o    (tick)
  );

  led_blink_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .ctrl_wr_i   (ctrl_wr),
    .new_en_i    (wr_data_i[SEL_W]),
    .period_i    (period),
    .on_time_i   (on_time),
    .stop_load_i (stop_cnt),
    .auto_i      (ctrl.auto_stop),
    .mask_i      (ctrl.irq_mask),
    .run_o       (run),
    .led_o       (led_o),
    .irq_o       (irq_o)
  );
endmodule

// File: tb/led_blinker_bench.sv
module led_blinker_bench;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [6:0]  ctrl;
    logic [11:0] per;
    logic [11:0] on_t;
    logic [15:0] cnt;
    logic [7:0]  wait_n;
    logic        led;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  // ctrl: [6] mask, [5] auto-stop, [4] run, [3:0] divide select (R9 layout)
  localparam vec_t VEC [NV] = '{
    '{7'h1D, 12'd3, 12'd2, 16'd0, 8'd0, 1'b1, 1'b0, 4'd6},  // R6 restart at phase 0
    '{7'h1D, 12'd3, 12'd2, 16'd0, 8'd2, 1'b0, 1'b0, 4'd5},  // R5 phase 2 not below 2
    '{7'h1D, 12'd3, 12'd2, 16'd0, 8'd5, 1'b1, 1'b0, 4'd4},  // R4 wrap: 5 mod 4 = 1
    '{7'h1C, 12'd3, 12'd2, 16'd0, 8'd4, 1'b0, 1'b0, 4'd2},  // R2 sel 12: phase 2
    '{7'h1C, 12'd3, 12'd2, 16'd0, 8'd9, 1'b1, 1'b0, 4'd2},  // R2 sel 12: phase 0
    '{7'h1F, 12'd3, 12'd2, 16'd0, 8'd2, 1'b0, 1'b0, 4'd3},  // R3 sel 15 acts as 13
    '{7'h1F, 12'd3, 12'd2, 16'd0, 8'd5, 1'b1, 1'b0, 4'd3},  // R3
    '{7'h1D, 12'd3, 12'd0, 16'd0, 8'd1, 1'b0, 1'b0, 4'd5},  // R5 on-time 0
    '{7'h1D, 12'd3, 12'd5, 16'd0, 8'd3, 1'b1, 1'b0, 4'd5},  // R5 on-time above period
    '{7'h0D, 12'd3, 12'd5, 16'd0, 8'd3, 1'b0, 1'b0, 4'd6},  // R6 disabled stays dark
    '{7'h3D, 12'd1, 12'd1, 16'd3, 8'd4, 1'b1, 1'b0, 4'd7},  // R7 still running
    '{7'h3D, 12'd1, 12'd1, 16'd3, 8'd6, 1'b0, 1'b1, 4'd7},  // R7 stopped after 3
    '{7'h3D, 12'd1, 12'd1, 16'd3, 8'd8, 1'b0, 1'b1, 4'd8},  // R8 flag sticky
    '{7'h7D, 12'd1, 12'd1, 16'd2, 8'd6, 1'b0, 1'b0, 4'd8},  // R8 masked
    '{7'h3D, 12'd1, 12'd2, 16'd0, 8'd1, 1'b1, 1'b0, 4'd7},  // R7 count 0 runs one period
    '{7'h3D, 12'd1, 12'd2, 16'd0, 8'd2, 1'b0, 1'b1, 4'd7}   // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        led, irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_blinker u_led_blinker (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .led_o     (led),
    .irq_o     (irq)
  );

  // called at a falling edge; captured at the next rising edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic chk(input string req, input logic l_exp, input logic i_exp);
    n_chk++;
    if (led !== l_exp || irq !== i_exp) begin
      n_bad++;
      $display("FAIL %s: led=%b irq=%b expected led=%b irq=%b", req, led, irq, l_exp, i_exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wr(4'h4, 16'(VEC[i].per));
      wr(4'h8, 16'(VEC[i].on_t));
      wr(4'hC, VEC[i].cnt);
      wr(4'h0, 16'(VEC[i].ctrl));
      repeat (int'(VEC[i].wait_n)) @(negedge clk);
      chk($sformatf("R%0d", VEC[i].req), VEC[i].led, VEC[i].irq);
    end

    // R8 collision: completion and control write on the same edge
    wr(4'h4, 16'd1);
    wr(4'h8, 16'd1);
    wr(4'hC, 16'd1);
    wr(4'h0, 16'h003D);
    @(negedge clk);
    wr(4'h0, 16'h001D);
    chk("R8", 1'b1, 1'b1);
    wr(4'h0, 16'h001D);
    chk("R8", 1'b1, 1'b0);

    // R9 stop count only latched at control write
    wr(4'hC, 16'd1);
    wr(4'h0, 16'h003D);
    wr(4'hC, 16'd5);
    @(negedge clk);
    chk("R9", 1'b0, 1'b1);

    // R6 halt mid-run
    wr(4'h8, 16'd2);
    wr(4'h0, 16'h001D);
    wr(4'h0, 16'h000D);
    chk("R6", 1'b0, 1'b0);

    // R1 reset mid-run
    wr(4'h0, 16'h003D);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule